// File: doc/BRIEF.md
# Nonvolatile Write Permission Gate

This block sits between the serial command decoder and the nonvolatile memory controller of a supervisor device with an embedded EEPROM. Each time the decoder wants to start a nonvolatile write, it presents a one-cycle request with the target, which is either the main byte array or the control register, and the byte address. The block answers in the next cycle with exactly one pulse: a grant or a denial. Only a granted request may start a write. A denied request starts nothing.

The decision depends on several inputs. For the array, it depends on a 3-bit lock selector that marks an upper region as read-only. That region is either a fraction of the array or a small whole number of pages. For the control register, the write-enable latch must be set, and the write-protect pin together with its enable bit can lock the register. The block also watches the supervisor's reset output. While that reset is active, no new write may begin. A write that was granted before the reset keeps its busy state until the memory controller reports completion.

Top module: `wpg_gate`

## Requirements
- R1: After the synchronous active-low block reset, `grant`, `deny` and `busy` are all low.
- R2: For an array request, `lock_sel` selects the read-only upper region. With `DEPTH` bytes and `PAGE`-byte pages, the region sizes are: 0 = none, 1 = upper quarter, 2 = upper half, 3 = whole array, 4 = 1 page, 5 = 2 pages, 6 = 4 pages, 7 = 8 pages, each counted down from address `DEPTH-1`. A request to any address inside the region is denied.
- R3: An array request to an address below the read-only region is granted. The write-enable latch input plays no part in this decision.
- R4: A control-register request is denied whenever `wel` is low.
- R5: A control-register request is denied when `wp_pin` and `wpen` are both high. Either one alone does not block the request, and `lock_sel` has no effect on control-register requests.
- R6: While `sys_rst` is high, every request is denied.
- R7: Once granted, `busy` stays high until `nv_done` is seen. Asserting `sys_rst` does not clear `busy`.
- R8: A request made while `busy` is high is denied, and `busy` stays high.
- R9: Each request produces exactly one one-cycle pulse, on `grant` or on `deny`, in the cycle after the request. A denial leaves `busy` unchanged.
- R10: `busy` falls in the cycle after `nv_done` is seen while busy. A pulse on `nv_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| req_valid | input | 1 | One-cycle request to start a nonvolatile write |
| req_is_ctrl | input | 1 | 1 = control-register target, 0 = array target |
| req_addr | input | ADDR_W | Byte address of an array request |
| wp_pin | input | 1 | Write-protect pin level |
| wpen | input | 1 | Write-protect enable bit |
| wel | input | 1 | Write-enable latch bit |
| lock_sel | input | 3 | Read-only region selector |
| sys_rst | input | 1 | Supervisor reset active (high) |
| nv_done | input | 1 | Memory controller reports the write finished |
| grant | output | 1 | Request accepted (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |
| busy | output | 1 | A granted write is still in progress |

## Verification
The hardest situation to reach from the ports is a reset that arrives in the middle of a write. To create it, the bench first obtains a grant. It then raises `sys_rst` for several cycles while holding back `nv_done`. It checks that `busy` survives the whole reset window and that a request made during that window is denied. Only then does it complete the write with `nv_done`.

The region boundaries are covered by sweeping all eight selector codes over the first and last byte of every page. Expected results come from region sizes computed in the bench.

// File: rtl/wpg_pkg.sv
// Shared definitions for the write permission gate.
// Assumes DEPTH is a multiple of 8*PAGE, so every region edge falls on a page boundary.
package wpg_pkg;

    typedef enum logic [2:0] {
        LOCK_NONE    = 3'd0,
        LOCK_QUARTER = 3'd1,
        LOCK_HALF    = 3'd2,
        LOCK_ALL     = 3'd3,
        LOCK_PG1     = 3'd4,
        LOCK_PG2     = 3'd5,
        LOCK_PG4     = 3'd6,
        LOCK_PG8     = 3'd7
    } lock_sel_e;

    // Lowest read-only address for a selector code. DEPTH means no region.
    function automatic int unsigned region_floor(input int unsigned code,
                                                 input int unsigned depth,
                                                 input int unsigned page);
        case (code)
            0:       return depth;
            1:       return depth - depth / 4;
            2:       return depth - depth / 2;
            3:       return 0;
            default: return depth - (page << (code - 4));
        endcase
    endfunction

endpackage

// File: rtl/wpg_region.sv
// Read-only region decode: flags an array address that lies inside the region
// chosen by the selector. Assumes the address is below DEPTH.
module wpg_region
    import wpg_pkg::*;
#(
    parameter int DEPTH  = 8192,
    parameter int PAGE   = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        lock_sel,
    output logic              in_region
);

    localparam int CMP_W  = ADDR_W + 1;
    localparam int N_CODE = 8;

    logic [N_CODE-1:0] hit;

    // One comparator per selector code against its computed floor.
    for (genvar k = 0; k < N_CODE; k++) begin : g_code
        localparam int unsigned FLOOR = region_floor(k, DEPTH, PAGE);
        if (FLOOR == 0) begin : g_all
            assign hit[k] = 1'b1;
        end else begin : g_cmp
            localparam logic [CMP_W-1:0] FLOOR_V = CMP_W'(FLOOR);
            assign hit[k] = ({1'b0, addr} >= FLOOR_V);
        end
    end

    // Choose the comparator that belongs to the active selector.
    always_comb begin
        in_region = hit[lock_sel];
    end

    // R2
    region_all_chk: assert final ((lock_sel != LOCK_ALL) || in_region);

endmodule

// File: rtl/wpg_ctrl_lock.sv
// Control-register permission: the write-enable latch must be set, and the
// pin plus its enable bit together lock the register. Purely combinational.
module wpg_ctrl_lock (
    input  logic wel,
    input  logic wp_pin,
    input  logic wpen,
    output logic ctrl_ok
);

    // Combine the latch requirement with the pin lock.
    always_comb begin
        ctrl_ok = wel && !(wp_pin && wpen);
    end

endmodule

// File: rtl/wpg_tracker.sv
// Decision register and in-progress tracker. Takes the combined permission,
// issues a one-cycle grant or deny, and holds busy from grant to completion.
// Assumes req_valid lasts one cycle per request. sys_rst never clears busy.
module wpg_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic permit,
    input  logic sys_rst,
    input  logic nv_done,
    output logic grant,
    output logic deny,
    output logic busy
);

    // Register the decision and track the running write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            deny  <= 1'b0;
            busy  <= 1'b0;
        end else begin
            grant <= 1'b0;
            deny  <= 1'b0;
            if (busy && nv_done) begin
                busy <= 1'b0;
            end
            if (req_valid) begin
                if (permit && !sys_rst && !busy) begin
                    grant <= 1'b1;
                    busy  <= 1'b1;
                end else begin
                    deny <= 1'b1;
                end
            end
        end
    end

    // R9
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));

    // R9
    answer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || deny));

    // R6
    no_grant_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sys_rst) |=> !grant);

    // R7
    busy_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !nv_done) |=> busy);

    // R8
    busy_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> deny);

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);

endmodule

// File: rtl/wpg_gate.sv
// Nonvolatile write permission gate (top). Routes array requests through the
// region decode and control requests through the register lock, then hands
// the combined permission to the tracker.
module wpg_gate
    import wpg_pkg::*;
#(
    parameter int DEPTH  = 8192,
    parameter int PAGE   = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_ctrl,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp_pin,
    input  logic              wpen,
    input  logic              wel,
    input  logic [2:0]        lock_sel,
    input  logic              sys_rst,
    input  logic              nv_done,
    output logic              grant,
    output logic              deny,
    output logic              busy
);

    logic in_region;
    logic ctrl_ok;
    logic permit;

    wpg_region #(.DEPTH(DEPTH), .PAGE(PAGE), .ADDR_W(ADDR_W)) region_i (
        .addr      (req_addr),
        .lock_sel  (lock_sel),
        .in_region (in_region)
    );

    wpg_ctrl_lock ctrl_i (
        .wel     (wel),
        .wp_pin  (wp_pin),
        .wpen    (wpen),
        .ctrl_ok (ctrl_ok)
    );

    // Select the permission rule that belongs to the request target.
    always_comb begin
        permit = req_is_ctrl ? ctrl_ok : !in_region;
    end

    wpg_tracker track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .permit    (permit),
        .sys_rst   (sys_rst),
        .nv_done   (nv_done),
        .grant     (grant),
        .deny      (deny),
        .busy      (busy)
    );

    // R4
    ctrl_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_ctrl && !wel) |=> !grant);

    // R5
    ctrl_pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_ctrl && wp_pin && wpen) |=> !grant);

    // R2
    array_all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_ctrl && lock_sel == LOCK_ALL) |=> !grant);

endmodule

// File: tb/wpg_gate_tb.sv
module wpg_gate_tb_top;

    localparam int DEPTH  = 8192;
    localparam int PAGE   = 64;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_is_ctrl;
    logic [ADDR_W-1:0] req_addr;
    logic              wp_pin;
    logic              wpen;
    logic              wel;
    logic [2:0]        lock_sel;
    logic              sys_rst;
    logic              nv_done;
    logic              grant;
    logic              deny;
    logic              busy;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    wpg_gate #(.DEPTH(DEPTH), .PAGE(PAGE), .ADDR_W(ADDR_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_ctrl (req_is_ctrl),
        .req_addr    (req_addr),
        .wp_pin      (wp_pin),
        .wpen        (wpen),
        .wel         (wel),
        .lock_sel    (lock_sel),
        .sys_rst     (sys_rst),
        .nv_done     (nv_done),
        .grant       (grant),
        .deny        (deny),
        .busy        (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int region_size(input int code);
        case (code)
            0:       return 0;
            1:       return DEPTH / 4;
            2:       return DEPTH / 2;
            3:       return DEPTH;
            default: return PAGE << (code - 4);
        endcase
    endfunction

    // Issue one request and check the answer in the next cycle.
    // A granted write is then completed with nv_done.
    task automatic issue(input bit ctrl, input int addr, input bit exp_g, input string tag);
        @(negedge clk);
        req_valid   = 1'b1;
        req_is_ctrl = ctrl;
        req_addr    = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        chk(grant == exp_g && deny == !exp_g, tag, {grant, deny}, {exp_g, !exp_g});
        chk(busy == exp_g, {tag, " busy"}, busy, exp_g);
        if (exp_g) begin
            nv_done = 1'b1;
            @(negedge clk);
            nv_done = 1'b0;
            chk(busy == 1'b0 && grant == 1'b0, "R10 busy clear", busy, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 0; req_is_ctrl = 0; req_addr = '0;
        wp_pin = 0; wpen = 0; wel = 0; lock_sel = 3'd0; sys_rst = 0; nv_done = 0;
        repeat (3) @(negedge clk);
        chk(!grant && !deny && !busy, "R1 reset state", {grant, deny, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!grant && !deny && !busy, "R1 after release", {grant, deny, busy}, 0);

        // Array sweep: first and last byte of every page for every selector code.
        for (int code = 0; code < 8; code++) begin
            lock_sel = 3'(code);
            for (int pg = 0; pg < DEPTH / PAGE; pg++) begin
                for (int e = 0; e < 2; e++) begin
                    int a;
                    bit prot;
                    a = pg * PAGE + e * (PAGE - 1);
                    prot = (a >= DEPTH - region_size(code));
                    wel = 1'(pg);
                    issue(1'b0, a, !prot, prot ? "R2 region" : "R3 open");
                end
            end
        end

        // Control-register sweep: every latch, pin and enable combination.
        // The array lock stays at the whole array and must not matter here.
        lock_sel = 3'd3;
        for (int m = 0; m < 8; m++) begin
            wel = m[0]; wp_pin = m[1]; wpen = m[2];
            issue(1'b1, DEPTH - 1, m[0] && !(m[1] && m[2]),
                  !m[0] ? "R4 wel" : "R5 pin lock");
        end
        wp_pin = 0; wpen = 0; wel = 1; lock_sel = 3'd0;

        // Supervisor reset: every request is refused.
        sys_rst = 1'b1;
        issue(1'b0, 0, 1'b0, "R6 array");
        issue(1'b1, 0, 1'b0, "R6 ctrl");
        sys_rst = 1'b0;

        // Write in progress survives a supervisor reset.
        @(negedge clk);
        req_valid = 1; req_is_ctrl = 0; req_addr = '0;
        @(negedge clk);
        req_valid = 0;
        chk(grant && busy, "R7 grant", {grant, busy}, 3);
        sys_rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy, "R7 busy held", busy, 1);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(deny && !grant && busy, "R8 deny while busy", {grant, deny, busy}, 3);
        @(negedge clk);
        chk(!deny && busy, "R9 single pulse", {deny, busy}, 1);
        sys_rst = 1'b0;
        @(negedge clk);
        chk(busy, "R8 busy kept", busy, 1);
        nv_done = 1;
        @(negedge clk);
        nv_done = 0;
        chk(!busy, "R10 done", busy, 0);

        // Completion pulse while idle does nothing.
        nv_done = 1;
        @(negedge clk);
        nv_done = 0;
        @(negedge clk);
        chk(!busy && !grant && !deny, "R10 idle done", {grant, deny, busy}, 0);

        // Block reset clears a running write.
        issue(1'b0, 5, 1'b1, "R3 before reset");
        @(negedge clk);
        req_valid = 1; req_addr = ADDR_W'(7);
        @(negedge clk);
        req_valid = 0;
        rst_n = 0;
        @(negedge clk);
        chk(!grant && !deny && !busy, "R1 reset mid write", {grant, deny, busy}, 0);
        rst_n = 1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule